// File: doc/BRIEF.md
# Per-pin LED brightness and blink modulator

This block drives one modulated bit for each of 32 LED lines. Every line has its own 8-bit brightness value, turned into a pulse-width signal by one shared free-running 8-bit counter. A line may also be switched to blink mode. The pulse-width bit is then masked by a 50 % square-wave gate, which toggles at a rate taken from one of three strobe inputs. The 32-bit result is registered and handed to a downstream serial shifter.

Blink timing is held in nine configuration slots, each 6 bits wide. Lines 24 to 31 each own a slot. Lines 0 to 23 share one common slot. Each slot chooses a strobe source and a divider. Rewriting a slot with a new value restarts its gate from a known phase, so a line never shows a shortened pulse. Software reaches the block through a simple write-only word port.

Top module: `led_blink_dim`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `led_o` is all zeros. All brightness values, blink enables and slot words reset to zero.
- R2: A line whose brightness value is 0x00 is never high. A line whose brightness value is 0xFF and whose blink bit is clear is high on every cycle.
- R3: With the blink bit clear, a line whose brightness value d lies between 0x01 and 0xFE is high on exactly d cycles of any 256 consecutive cycles.
- R4: When a line's bit in the blink-enable word is clear, that line follows its pulse-width signal alone, whatever its slot holds.
- R5: When a line's blink bit is set, the line is high only while both its pulse-width signal and its slot's gate are high. The gate is a square wave that changes level only on a strobe of the selected source or on a restart.
- R6: Source code 0 counts `ref_pulse_i` strobes. Rate code 0, 1, 2 or 3 in slot bits 1:0 toggles the gate every 4000, 2000, 1000 or 800 strobes respectively.
- R7: Source code 1 counts `tmr_pulse_i` strobes, using the same four divisors, selected by slot bits 3:2.
- R8: Source code 2 toggles the gate on every `hs_pulse_i` strobe. Source code 3 holds the gate low. The source code sits in slot bits 5:4.
- R9: The word at byte address 0x00 holds, in its bits 6k+5:6k, the slot for line 24+k (k = 0..4). The word at 0x04 holds, in bits 6k+5:6k, the slot for line 29+k (k = 0..2). Bits 23:18 of that word form the slot shared by lines 0 to 23.
- R10: A write that changes a slot's 6-bit value clears that slot's gate and counter. The gate then first rises after exactly one full divide interval. A write that leaves a slot's value unchanged does not disturb its gate.
- R11: Brightness of line p is written at byte address 0x08 + 4·p, from data bits 7:0. The blink-enable word is at 0x88, with bit p belonging to line p. Writes to any other address, including addresses not aligned to a word, change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, one word per cycle |
| wr_addr_i | input | 8 | Byte address of the write |
| wr_data_i | input | 32 | Write data |
| ref_pulse_i | input | 1 | Single-cycle strobe from the divided reference clock |
| tmr_pulse_i | input | 1 | Single-cycle strobe from the general-purpose timer |
| hs_pulse_i | input | 1 | Single-cycle strobe from the high-speed timer, used undivided |
| led_o | output | 32 | Registered modulated bit per line, toward the shifter |

## Verification
The assertions assume that the three strobe inputs are synchronous to `clk`, last one cycle each, and change only while reset is released. They also assume that every write is a full word presented for exactly one cycle. The bench meets these assumptions by driving each strobe from a counter on the falling edge, with fixed spacings of 1, 2 and 4 cycles, and by holding `wr_en_i` for a single cycle in each write. Because the spacings are fixed, every expected high-cycle count over a window can be worked out in closed form.

// File: rtl/lbd_pkg.sv
// Shared constants and types for the LED brightness/blink modulator.
// Assumes a fixed 32-line layout with nine blink slots (8 private, 1 shared).
package lbd_pkg;

    localparam int NPINS    = 32;
    localparam int NSLOTS   = 9;
    localparam int SLOT_W   = 6;
    localparam int SHARED_S = 8;   // slot used by the lower 24 lines
    localparam int LOW_PINS = 24;  // lines below this index share a slot

    typedef enum logic [1:0] {
        SRC_REF  = 2'd0,
        SRC_TMR  = 2'd1,
        SRC_HS   = 2'd2,
        SRC_HOLD = 2'd3
    } blink_src_e;

    // Packed slot layout: source in 5:4, timer rate 3:2, reference rate 1:0
    typedef struct packed {
        blink_src_e src;
        logic [1:0] tmr_rate;
        logic [1:0] ref_rate;
    } slot_cfg_t;

endpackage

// File: rtl/lbd_regs.sv
// Write-only register bank: per-line brightness, blink enables and two
// packed slot words. It also flags any slot whose value a write alters.
// Assumes one full-word write per cycle. Unmapped or unaligned addresses are dropped.
module lbd_regs
    import lbd_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DUTY_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [31:0]        wr_data_i,
    output logic [DUTY_W-1:0]  duty_o [NPINS],
    output logic [NPINS-1:0]   blink_en_o,
    output slot_cfg_t          slot_o [NSLOTS],
    output logic [NSLOTS-1:0]  restart_o
);
    localparam int PIN_W     = $clog2(NPINS);
    localparam int A_BITS    = 5 * SLOT_W;
    localparam int B_BITS    = 4 * SLOT_W;
    localparam logic [ADDR_W-1:0] ADR_A     = ADDR_W'(8'h00);
    localparam logic [ADDR_W-1:0] ADR_B     = ADDR_W'(8'h04);
    localparam logic [ADDR_W-1:0] DUTY_BASE = ADDR_W'(8'h08);
    localparam logic [ADDR_W-1:0] DUTY_END  = ADDR_W'(8'h08 + 4 * NPINS);
    localparam logic [ADDR_W-1:0] ADR_EN    = ADDR_W'(8'h88);

    logic [A_BITS-1:0] word_a_q, word_a_nxt;
    logic [B_BITS-1:0] word_b_q, word_b_nxt;
    logic              duty_hit;
    logic [ADDR_W-1:0] duty_off;
    logic [PIN_W-1:0]  duty_sel;

    // Decode a brightness write and the line it targets
    always_comb begin
        duty_off = wr_addr_i - DUTY_BASE;
        duty_sel = duty_off[2 +: PIN_W];
        duty_hit = wr_en_i && (wr_addr_i[1:0] == 2'b00) &&
                   (wr_addr_i >= DUTY_BASE) && (wr_addr_i < DUTY_END);
    end

    // Next value of both slot words, used for storage and change detection
    always_comb begin
        word_a_nxt = (wr_en_i && wr_addr_i == ADR_A) ? wr_data_i[A_BITS-1:0] : word_a_q;
        word_b_nxt = (wr_en_i && wr_addr_i == ADR_B) ? wr_data_i[B_BITS-1:0] : word_b_q;
    end

    // Slot words and blink-enable word storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_a_q   <= '0;
            word_b_q   <= '0;
            blink_en_o <= '0;
        end else begin
            word_a_q <= word_a_nxt;
            word_b_q <= word_b_nxt;
            if (wr_en_i && wr_addr_i == ADR_EN)
                blink_en_o <= wr_data_i[NPINS-1:0];
        end
    end

    genvar p, s;
    generate
        for (p = 0; p < NPINS; p++) begin : g_duty
            // Brightness value of one line
            always_ff @(posedge clk) begin
                if (!rst_n)
                    duty_o[p] <= '0;
                else if (duty_hit && duty_sel == PIN_W'(p))
                    duty_o[p] <= wr_data_i[DUTY_W-1:0];
            end
        end
        for (s = 0; s < NSLOTS; s++) begin : g_slot
            if (s < 5) begin : g_a
                assign slot_o[s]    = word_a_q[s*SLOT_W +: SLOT_W];
                assign restart_o[s] = word_a_nxt[s*SLOT_W +: SLOT_W] !=
                                      word_a_q[s*SLOT_W +: SLOT_W];
            end else begin : g_b
                assign slot_o[s]    = word_b_q[(s-5)*SLOT_W +: SLOT_W];
                assign restart_o[s] = word_b_nxt[(s-5)*SLOT_W +: SLOT_W] !=
                                      word_b_q[(s-5)*SLOT_W +: SLOT_W];
            end
        end
    endgenerate

endmodule

// File: rtl/lbd_pwm.sv
// Shared free-running counter and one comparator per line.
// Line is high while counter < value. The all-ones value forces constant high.
module lbd_pwm
    import lbd_pkg::*;
#(
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] duty_i [NPINS],
    output logic [NPINS-1:0]  pwm_o
);
    logic [DUTY_W-1:0] phase_q;

    // Free-running phase counter, wraps every 2**DUTY_W cycles
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_q + 1'b1;
    end

    genvar p;
    generate
        for (p = 0; p < NPINS; p++) begin : g_cmp
            assign pwm_o[p] = (duty_i[p] == '1) || (phase_q < duty_i[p]);
        end
    endgenerate

endmodule

// File: rtl/lbd_blink_slot.sv
// Square-wave gate for one blink slot. It counts strobes of the chosen
// source and toggles the gate after the divisor picked by the rate code.
// Assumes strobes are single-cycle and synchronous. A restart zeroes phase.
module lbd_blink_slot
    import lbd_pkg::*;
#(
    parameter int DIV_W = 12,
    parameter int DIV0  = 4000,
    parameter int DIV1  = 2000,
    parameter int DIV2  = 1000,
    parameter int DIV3  = 800
) (
    input  logic      clk,
    input  logic      rst_n,
    input  slot_cfg_t cfg_i,
    input  logic      restart_i,
    input  logic      ref_p_i,
    input  logic      tmr_p_i,
    input  logic      hs_p_i,
    output logic      gate_o
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim;
    logic             step;

    // Pick the active strobe and terminal count for the selected source
    always_comb begin
        logic [1:0] rate;
        rate = (cfg_i.src == SRC_TMR) ? cfg_i.tmr_rate : cfg_i.ref_rate;
        case (rate)
            2'd0:    lim = DIV_W'(DIV0 - 1);
            2'd1:    lim = DIV_W'(DIV1 - 1);
            2'd2:    lim = DIV_W'(DIV2 - 1);
            default: lim = DIV_W'(DIV3 - 1);
        endcase
        step = (cfg_i.src == SRC_REF) ? ref_p_i :
               (cfg_i.src == SRC_TMR) ? tmr_p_i : 1'b0;
    end

    // Divider counter and gate flip-flop
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            cnt_q  <= '0;
            gate_o <= 1'b0;
        end else begin
            case (cfg_i.src)
                SRC_HS: begin
                    cnt_q <= '0;
                    if (hs_p_i) gate_o <= ~gate_o;
                end
                SRC_HOLD: begin
                    cnt_q  <= '0;
                    gate_o <= 1'b0;
                end
                default: begin
                    if (step) begin
                        if (cnt_q >= lim) begin
                            cnt_q  <= '0;
                            gate_o <= ~gate_o;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/led_blink_dim.sv
// Top: per-line dimming combined with slot-driven blink gating. The output
// is registered for the downstream shifter. Lines below 24 share slot 8.
module led_blink_dim
    import lbd_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DUTY_W = 8,
    parameter int DIV_W  = 12,
    parameter int DIV0   = 4000,
    parameter int DIV1   = 2000,
    parameter int DIV2   = 1000,
    parameter int DIV3   = 800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [31:0]       wr_data_i,
    input  logic              ref_pulse_i,
    input  logic              tmr_pulse_i,
    input  logic              hs_pulse_i,
    output logic [NPINS-1:0]  led_o
);
    logic [DUTY_W-1:0] duty_q [NPINS];
    logic [NPINS-1:0]  blink_en;
    slot_cfg_t         slot_cfg [NSLOTS];
    logic [1:0]        slot_src [NSLOTS];
    logic [NSLOTS-1:0] slot_restart;
    logic [NSLOTS-1:0] slot_gate;
    logic [NPINS-1:0]  pin_gate;
    logic [NPINS-1:0]  pwm;

    lbd_regs #(.ADDR_W(ADDR_W), .DUTY_W(DUTY_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .duty_o     (duty_q),
        .blink_en_o (blink_en),
        .slot_o     (slot_cfg),
        .restart_o  (slot_restart)
    );

    lbd_pwm #(.DUTY_W(DUTY_W)) pwm_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .duty_i (duty_q),
        .pwm_o  (pwm)
    );

    genvar s, p;
    generate
        for (s = 0; s < NSLOTS; s++) begin : g_slot
            assign slot_src[s] = slot_cfg[s].src;
            lbd_blink_slot #(
                .DIV_W(DIV_W), .DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)
            ) slot_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .cfg_i     (slot_cfg[s]),
                .restart_i (slot_restart[s]),
                .ref_p_i   (ref_pulse_i),
                .tmr_p_i   (tmr_pulse_i),
                .hs_p_i    (hs_pulse_i),
                .gate_o    (slot_gate[s])
            );
        end
        for (p = 0; p < NPINS; p++) begin : g_pin
            localparam int SIDX = (p < LOW_PINS) ? SHARED_S : p - LOW_PINS;
            assign pin_gate[p] = slot_gate[SIDX];
        end
    endgenerate

    // Register the combined dimming and blink result
    always_ff @(posedge clk) begin
        if (!rst_n) led_o <= '0;
        else        led_o <= pwm & (~blink_en | pin_gate);
    end

endmodule

// File: rtl/lbd_checker.sv
// Property checker for led_blink_dim, attached with bind below.
// Assumes strobes are synchronous to clk and only relates registered state.
module lbd_checker
    import lbd_pkg::*;
#(
    parameter int DUTY_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ref_pulse_i,
    input logic              tmr_pulse_i,
    input logic              hs_pulse_i,
    input logic [NPINS-1:0]  led_o,
    input logic [DUTY_W-1:0] duty_q [NPINS],
    input logic [NPINS-1:0]  blink_en,
    input logic [NPINS-1:0]  pin_gate,
    input logic [NSLOTS-1:0] slot_gate,
    input logic [NSLOTS-1:0] slot_restart,
    input logic [1:0]        slot_src [NSLOTS]
);
    // R1: first cycle out of reset shows all lines off
    assert_reset_dark_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> led_o == '0);

    genvar p, s;
    generate
        for (p = 0; p < NPINS; p++) begin : g_pin
            // R2: zero brightness never lights the line
            assert_zero_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (duty_q[p] == '0) |=> !led_o[p]);
            // R4: full brightness without blink is always on
            assert_full_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (duty_q[p] == '1 && !blink_en[p]) |=> led_o[p]);
            // R5: a low gate masks a blinking line
            assert_gate_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (blink_en[p] && !pin_gate[p]) |=> !led_o[p]);
        end
        for (s = 0; s < NSLOTS; s++) begin : g_slot
            // R5: gate moves only on a strobe or a restart
            assert_gate_still_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (!ref_pulse_i && !tmr_pulse_i && !hs_pulse_i && !slot_restart[s])
                |=> $stable(slot_gate[s]));
            // R8: hold source keeps the gate low
            assert_hold_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (slot_src[s] == 2'd3) |=> !slot_gate[s]);
            // R10: a changed slot restarts with its gate low
            assert_restart_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
                slot_restart[s] |=> !slot_gate[s]);
        end
    endgenerate

endmodule

bind led_blink_dim lbd_checker #(.DUTY_W(DUTY_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ref_pulse_i  (ref_pulse_i),
    .tmr_pulse_i  (tmr_pulse_i),
    .hs_pulse_i   (hs_pulse_i),
    .led_o        (led_o),
    .duty_q       (duty_q),
    .blink_en     (blink_en),
    .pin_gate     (pin_gate),
    .slot_gate    (slot_gate),
    .slot_restart (slot_restart),
    .slot_src     (slot_src)
);

// File: tb/led_blink_dim_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module led_blink_dim_tb_top;
    localparam time TCK = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [7:0]  wr_addr_i = '0;
    logic [31:0] wr_data_i = '0;
    logic        ref_pulse_i = 1'b0;
    logic        tmr_pulse_i = 1'b0;
    logic        hs_pulse_i = 1'b0;
    logic [31:0] led_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    int strobe_cnt = 0;

    led_blink_dim dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .ref_pulse_i(ref_pulse_i), .tmr_pulse_i(tmr_pulse_i),
        .hs_pulse_i(hs_pulse_i), .led_o(led_o)
    );

    always #(TCK/2) clk = ~clk;

    // Strobes: reference every cycle, timer every 2nd, high-speed every 4th
    initial begin
        forever begin
            @(negedge clk);
            strobe_cnt  = strobe_cnt + 1;
            ref_pulse_i = rst_n;
            tmr_pulse_i = rst_n && (strobe_cnt % 2 == 0);
            hs_pulse_i  = rst_n && (strobe_cnt % 4 == 0);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic skip(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic count_high(input int pin, input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (led_o[pin]) hi++;
        end
    endtask

    function automatic logic [7:0] duty_adr(input int p);
        return 8'(8 + 4 * p);
    endfunction

    task automatic t_reset();
        skip(1);
        check(led_o == '0, "R1 reset dark", int'(led_o), 0);
    endtask

    task automatic t_duty();
        int hi;
        wr(duty_adr(5), 32'h00); wr(duty_adr(6), 32'hFF);
        wr(duty_adr(7), 32'h40); wr(duty_adr(8), 32'h80); wr(duty_adr(9), 32'h01);
        skip(3);
        count_high(5, 256, hi); check(hi == 0,   "R2 duty 0x00",  hi, 0);
        count_high(6, 256, hi); check(hi == 256, "R2 duty 0xFF",  hi, 256);
        count_high(7, 256, hi); check(hi == 64,  "R3 duty 0x40",  hi, 64);
        count_high(8, 256, hi); check(hi == 128, "R3 duty 0x80",  hi, 128);
        count_high(9, 256, hi); check(hi == 1,   "R3 duty 0x01",  hi, 1);
    endtask

    task automatic t_ignore();
        int hi;
        wr(8'h09, 32'hFF); wr(8'h8C, 32'hFF); wr(8'h8A, 32'hFFFF_FFFF);
        skip(3);
        count_high(0, 256, hi); check(hi == 0, "R11 unmapped write ignored", hi, 0);
    endtask

    task automatic t_blink_off();
        int hi;
        wr(8'h04, 32'h3 << 18);
        wr(8'h88, 32'h0000_0080);   // blink only line 7
        skip(3);
        count_high(6, 1600, hi); check(hi == 1600, "R4 blink clear follows pwm", hi, 1600);
    endtask

    task automatic t_ref_source();
        int hi;
        wr(duty_adr(20), 32'hFF);
        wr(8'h88, 32'h0010_0040);   // lines 6 and 20 blink
        skip(3);
        count_high(6, 1600, hi);  check(hi == 800, "R6 ref rate3 div800", hi, 800);
        count_high(20, 1600, hi); check(hi == 800, "R9 shared slot line20", hi, 800);
        wr(8'h04, 32'h2 << 18);
        skip(3);
        count_high(6, 2000, hi);  check(hi == 1000, "R6 ref rate2 div1000", hi, 1000);
    endtask

    task automatic t_restart();
        int hi;
        wr(8'h04, 32'h3 << 18);     // slot change -> restart
        skip(4);
        count_high(6, 780, hi); check(hi == 0,  "R10 low after restart", hi, 0);
        skip(25);
        count_high(6, 80, hi);  check(hi == 80, "R10 rises after 800", hi, 80);
        wr(8'h04, 32'h3 << 18);     // same value -> no restart
        count_high(6, 500, hi); check(hi == 500, "R10 unchanged write keeps phase", hi, 500);
    endtask

    task automatic t_timer_source();
        int hi;
        wr(duty_adr(30), 32'hFF);
        wr(8'h04, (32'h3 << 18) | (32'h1C << 6));  // line 30: timer, rate3
        wr(8'h88, 32'h4000_0040);
        skip(3);
        count_high(30, 3200, hi); check(hi == 1600, "R7 timer rate3", hi, 1600);
    endtask

    task automatic t_hs_hold();
        int hi;
        wr(duty_adr(24), 32'hFF); wr(duty_adr(25), 32'hFF);
        wr(8'h00, 32'h0000_0830);   // line24 hold, line25 high-speed
        wr(8'h88, 32'h0300_0000);
        skip(3);
        count_high(24, 800, hi); check(hi == 0,   "R8 hold source low", hi, 0);
        count_high(25, 800, hi); check(hi == 400, "R8 R9 hs source line25", hi, 400);
        count_high(6, 256, hi);  check(hi == 256, "R4 line6 no longer blinking", hi, 256);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        skip(5);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_duty();
        t_ignore();
        t_blink_off();
        t_ref_source();
        t_restart();
        t_timer_source();
        t_hs_hold();
        done = 1'b1;
        finish_run();
    end

    // Watchdog
    initial begin
        #(TCK * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            finish_run();
        end
    end

endmodule